// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block decides which of several devices may drive a shared bus. Every device raises its own request. The requests are OR-ed into one shared request line that the channel sees. While the shared busy line is low, the channel sends out a single grant pulse. The grant starts at an entry cell and passes from cell to cell. A cell that is not requesting forwards the grant. The first requesting cell it reaches keeps it, takes ownership on the next clock edge and so raises busy. The owner keeps the bus until it pulses its done strobe. Ownership then drops and busy falls. The channel then keeps its grant low for one more cycle before it offers the bus again.

A mode pin selects how the entry point is chosen. In fixed mode the grant always enters at device 0, the cell nearest the channel, so chain position alone sets priority. In rotating mode the grant enters at the device after the most recent owner and wraps around the chain. The block then behaves as round-robin. If no device is requesting, no grant is issued. Grant propagation through the chain is combinational within a cycle; ownership is a register. Data, address and bus control signals are not part of this block, so no handshake appears at its edge: all pins are plain control levels.

Top module: `daisy_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every ownership flag and the busy output are 0. In rotating mode the first entry point after reset is device 0.
- R2: The channel grant is 1 only when at least one device request is 1. With all requests 0, the channel grant and every forwarded grant are 0.
- R3: Device d forwards the grant (dev_grant_out bit d = 1) exactly when the grant reaches it and dev_req bit d is 0. A requesting device never forwards.
- R4: A device that receives the grant while requesting owns the bus from the next clock edge. bus_busy is 1 whenever a device owns the bus, and at most one dev_owns bit is ever 1.
- R5: An owner that sees its dev_done bit at 1 on a clock edge gives up ownership at that edge. A done strobe from a device that does not own the bus has no effect. Ownership does not otherwise change while it is held.
- R6: The channel grant is 0 while bus_busy is 1 and on the cycle right after bus_busy falls.
- R7: With rr_mode = 0, the requesting device with the lowest index wins.
- R8: With rr_mode = 1, the grant enters at the device whose index is one above the last owner, wrapping from N_DEV-1 to 0, and the nearest requester in that ring order wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rr_mode | input | 1 | 0 = fixed chain priority, 1 = rotating entry point |
| dev_req | input | N_DEV | Per-device bus request, bit d belongs to device d |
| dev_done | input | N_DEV | Per-device end-of-transfer strobe |
| dev_owns | output | N_DEV | Per-device ownership flag, registered |
| dev_grant_out | output | N_DEV | Grant forwarded by each device to its chain neighbour |
| bus_busy | output | 1 | Shared busy line, high while any device owns the bus |
| chan_grant | output | 1 | Grant issued by the channel into the chain |

## Verification
The bench builds the arbiter with N_DEV = 5, so the pointer index uses three bits but only five codes. This means the rotating wrap from device 4 back to device 0 does not fall on a power-of-two boundary. With five cells, the grant can enter in the middle of the chain, pass through the top cell and come back around to cells below the entry point. The random phase also toggles the mode pin while devices hold ownership, which tests how the stored last owner carries over from one mode to the other.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;

  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_ROTATE = 1'b1
  } arb_mode_e;

  // Ring successor of an index in a chain of n cells.
  function automatic int ring_after(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/dc_channel.sv
`timescale 1ns/1ps
module dc_channel #(
  parameter int N_DEV = 4,
  localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rr_mode,
  input  logic          req_any,
  input  logic          busy,
  input  logic          take_valid,
  input  logic [IW-1:0] take_idx,
  output logic          grant,
  output logic [IW-1:0] start_idx
);
  import dc_pkg::*;

  arb_mode_e     mode;
  logic          busy_q;
  logic [IW-1:0] last_q;

  assign mode = arb_mode_e'(rr_mode);

  // Issue a grant only with a pending request, an idle line and one idle
  // cycle behind us, so a release and a fresh grant never share a cycle.
  assign grant = req_any & ~busy & ~busy_q;

  assign start_idx = (mode == MODE_ROTATE) ? IW'(ring_after(int'(last_q), N_DEV)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= IW'(N_DEV - 1);
    end else begin
      busy_q <= busy;
      if (take_valid) last_q <= take_idx;
    end
  end

endmodule

// File: rtl/dc_chain.sv
`timescale 1ns/1ps
module dc_chain #(
  parameter int N_DEV = 4,
  localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             grant,
  input  logic [IW-1:0]    start_idx,
  input  logic [N_DEV-1:0] req,
  output logic [N_DEV-1:0] arrive
);
  // The ring is unrolled into 2*N_DEV linear positions: injection happens at
  // position start_idx and the walk is cut after N_DEV positions, so no
  // combinational loop exists even though the grant may wrap.
  always_comb begin
    logic carry;
    int   s;
    int   d;
    arrive = '0;
    carry  = 1'b0;
    s      = int'(start_idx);
    for (int p = 0; p < 2 * N_DEV; p++) begin
      d = p % N_DEV;
      if (p == s)          carry = grant;
      if (p >= s + N_DEV)  carry = 1'b0;
      arrive[d] = arrive[d] | carry;
      carry     = carry & ~req[d];
    end
  end

endmodule

// File: rtl/dc_cell.sv
`timescale 1ns/1ps
module dc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_in,
  input  logic req,
  input  logic done,
  output logic grant_out,
  output logic take,
  output logic owns
);
  assign take      = grant_in & req;
  assign grant_out = grant_in & ~req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            owns <= 1'b0;
    else if (owns && done) owns <= 1'b0;
    else if (take)         owns <= 1'b1;
  end

endmodule

// File: rtl/daisy_arbiter.sv
`timescale 1ns/1ps
module daisy_arbiter #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rr_mode,
  input  logic [N_DEV-1:0] dev_req,
  input  logic [N_DEV-1:0] dev_done,
  output logic [N_DEV-1:0] dev_owns,
  output logic [N_DEV-1:0] dev_grant_out,
  output logic             bus_busy,
  output logic             chan_grant
);
  localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  logic             req_any;
  logic [N_DEV-1:0] arrive;
  logic [N_DEV-1:0] take;
  logic [IW-1:0]    start_idx;
  logic [IW-1:0]    take_idx;

  assign req_any  = |dev_req;   // shared wired-OR request line
  assign bus_busy = |dev_owns;  // shared busy line driven by the owner

  always_comb begin
    take_idx = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (take[i]) take_idx = IW'(i);
    end
  end

  dc_channel #(.N_DEV(N_DEV)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .rr_mode    (rr_mode),
    .req_any    (req_any),
    .busy       (bus_busy),
    .take_valid (|take),
    .take_idx   (take_idx),
    .grant      (chan_grant),
    .start_idx  (start_idx)
  );

  dc_chain #(.N_DEV(N_DEV)) u_chain (
    .grant     (chan_grant),
    .start_idx (start_idx),
    .req       (dev_req),
    .arrive    (arrive)
  );

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    dc_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant_in  (arrive[g]),
      .req       (dev_req[g]),
      .done      (dev_done[g]),
      .grant_out (dev_grant_out[g]),
      .take      (take[g]),
      .owns      (dev_owns[g])
    );
  end

endmodule

// File: rtl/daisy_arbiter_chk.sv
`timescale 1ns/1ps
module daisy_arbiter_chk #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rr_mode,
  input logic [N_DEV-1:0] dev_req,
  input logic [N_DEV-1:0] dev_done,
  input logic [N_DEV-1:0] dev_owns,
  input logic [N_DEV-1:0] dev_grant_out,
  input logic             bus_busy,
  input logic             chan_grant
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dev_owns == '0 && !bus_busy));

  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    chan_grant |-> (|dev_req));

  a_r3_no_forward_when_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_grant_out & dev_req) == '0);

  a_r4_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_owns));

  a_r4_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    chan_grant |=> bus_busy);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dev_owns & dev_done)) |=> !bus_busy);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !(|(dev_owns & dev_done))) |=> $stable(dev_owns));

  a_r6_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !chan_grant);

  a_r6_gap_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> !chan_grant);

  a_r7_nearest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_grant && !rr_mode) |=>
      (dev_owns == ($past(dev_req) & (~$past(dev_req) + 1'b1))));

endmodule

bind daisy_arbiter daisy_arbiter_chk #(.N_DEV(N_DEV)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rr_mode       (rr_mode),
  .dev_req       (dev_req),
  .dev_done      (dev_done),
  .dev_owns      (dev_owns),
  .dev_grant_out (dev_grant_out),
  .bus_busy      (bus_busy),
  .chan_grant    (chan_grant)
);

// File: tb/sim_daisy_arbiter.sv
`timescale 1ns/1ps
module sim_daisy_arbiter;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rr_mode = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic [N-1:0] dev_done = '0;
  logic [N-1:0] dev_owns;
  logic [N-1:0] dev_grant_out;
  logic         bus_busy;
  logic         chan_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic [N-1:0] m_owns;
  logic         m_busyq;
  int           m_last;

  always #4 clk = ~clk;

  daisy_arbiter #(.N_DEV(N)) u0 (
    .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .dev_req(dev_req),
    .dev_done(dev_done), .dev_owns(dev_owns), .dev_grant_out(dev_grant_out),
    .bus_busy(bus_busy), .chan_grant(chan_grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int f_start(input logic rr, input int last);
    return rr ? ((last + 1) % N) : 0;
  endfunction

  function automatic logic f_cg(input logic [N-1:0] req, input logic [N-1:0] owns, input logic bq);
    return (req != '0) && (owns == '0) && !bq;
  endfunction

  // Walk the ring from the entry point; the first requester keeps the grant.
  function automatic int f_winner(input logic [N-1:0] req, input logic cg, input int start);
    if (!cg) return -1;
    for (int k = 0; k < N; k++) if (req[(start + k) % N]) return (start + k) % N;
    return -1;
  endfunction

  function automatic logic [N-1:0] f_pass(input logic [N-1:0] req, input logic cg, input int start);
    logic [N-1:0] r;
    r = '0;
    if (cg) begin
      for (int k = 0; k < N; k++) begin
        if (req[(start + k) % N]) break;
        r[(start + k) % N] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [N-1:0] req, input logic [N-1:0] done, input logic rr);
    logic cg;
    @(negedge clk);
    dev_req = req; dev_done = done; rr_mode = rr;
    #1;
    cg = f_cg(req, m_owns, m_busyq);
    chk("R4 ownership", 32'(dev_owns), 32'(m_owns));
    chk("R4 busy", 32'(bus_busy), 32'(|m_owns));
    chk("R6 channel grant", 32'(chan_grant), 32'(cg));
    chk("R3 forwarded grant", 32'(dev_grant_out), 32'(f_pass(req, cg, f_start(rr, m_last))));
  endtask

  task automatic tick();
    logic [N-1:0] nxt;
    logic         cg;
    int           w;
    cg  = f_cg(dev_req, m_owns, m_busyq);
    w   = f_winner(dev_req, cg, f_start(rr_mode, m_last));
    nxt = m_owns;
    for (int d = 0; d < N; d++) begin
      if (m_owns[d] && dev_done[d]) nxt[d] = 1'b0;
      else if (w == d)              nxt[d] = 1'b1;
    end
    @(posedge clk);
    m_busyq = |m_owns;
    m_owns  = nxt;
    if (w >= 0) m_last = w;
  endtask

  task automatic cyc(input logic [N-1:0] req, input logic [N-1:0] done, input logic rr);
    drive(req, done, rr);
    tick();
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rq, dn;
    logic         rr;
    m_owns = '0; m_busyq = 1'b0; m_last = N - 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    drive('0, '0, 1'b0);
    chk("R1 owns after reset", 32'(dev_owns), 32'h0);
    chk("R1 busy after reset", 32'(bus_busy), 32'h0);
    chk("R2 no grant without request", 32'(chan_grant), 32'h0);
    chk("R2 no forwarding without request", 32'(dev_grant_out), 32'h0);
    tick();

    // R3: grant passes devices 0 and 1 and stops at 2
    drive(5'b00100, '0, 1'b0);
    chk("R3 pass to device 2", 32'(dev_grant_out), 32'h03);
    tick();
    // R5: done from a non-owner is ignored
    drive(5'b00101, 5'b00001, 1'b0);
    chk("R6 no grant while busy", 32'(chan_grant), 32'h0);
    tick();
    drive(5'b00101, 5'b00100, 1'b0);
    chk("R5 foreign done ignored", 32'(dev_owns), 32'h04);
    tick();
    // R6: one idle cycle after release
    drive(5'b00101, '0, 1'b0);
    chk("R5 released", 32'(dev_owns), 32'h0);
    chk("R6 gap after release", 32'(chan_grant), 32'h0);
    tick();
    drive(5'b00101, '0, 1'b0);
    chk("R6 grant after gap", 32'(chan_grant), 32'h1);
    tick();
    drive(5'b00101, 5'b00001, 1'b0);
    chk("R7 nearest device wins", 32'(dev_owns), 32'h01);
    tick();
    // R8: rotating, last owner 0 -> entry at 1 -> device 2 wins
    cyc(5'b00101, '0, 1'b1);
    cyc(5'b00101, '0, 1'b1);
    drive(5'b10011, 5'b00100, 1'b1);
    chk("R8 rotate to device 2", 32'(dev_owns), 32'h04);
    tick();
    cyc(5'b10011, '0, 1'b1);
    cyc(5'b10011, '0, 1'b1);
    drive(5'b10011, 5'b10000, 1'b1);
    chk("R8 rotate past device 3 to 4", 32'(dev_owns), 32'h10);
    tick();
    cyc(5'b10011, '0, 1'b1);
    cyc(5'b10011, '0, 1'b1);
    drive('0, 5'b00001, 1'b1);
    chk("R8 wrap to device 0", 32'(dev_owns), 32'h01);
    tick();
    cyc('0, '0, 1'b1);
    drive('0, '0, 1'b1);
    chk("R8 grant withdrawn when idle", 32'(chan_grant), 32'h0);
    tick();

    // random phase
    void'($urandom(32'd4242));
    rr = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(199) == 0) rr = ~rr;
      for (int d = 0; d < N; d++) begin
        rq[d] = ($urandom_range(99) < 40);
        dn[d] = m_owns[d] ? ($urandom_range(99) < 30) : ($urandom_range(99) < 10);
      end
      cyc(rq, dn, rr);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule